// File: doc/BRIEF.md
# Four-Step LED Pattern Sequencer with Run/Pause Button

This block drives an 8-bit LED vector through a fixed loop of four values. The loop advances slowly enough for a person to see each value. One push-button switches the loop between running and paused. Bit 7 of the output is the leftmost LED. Only the pattern value ever appears on the pins. No binary count of the step is shown.

A single fast clock drives the block. A synchronous, active-low reset returns it to its first value. After reset the loop is paused. The raw button first passes through a synchronizer and a debounce filter. The filtered level then goes to a rising-edge detector. Each press therefore gives one pulse, and that pulse flips the run state.

A prescaler makes the step tick. It counts only while the loop is running. Every toggle clears it, so a resumed loop waits one full step period before its first move. A 2-bit step index passes through a combinational lookup, and the result feeds a registered LED output.

Top module: `led_pattern_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `led_o` becomes 8'h00 at that edge. After `rst_n` is released, the block is paused and shows 8'h00 until a press is accepted.
- R2: Every change of `led_o` moves to the next value of the cycle 8'h00 → 8'h03 → 8'h40 → 8'hE8 → 8'h00. Bit 7 is the leftmost LED.
- R3: While running, each value stays on `led_o` for exactly `TICK_CYCLES` clocks between two successive changes.
- R4: Each accepted rising edge of the debounced button flips between running and paused exactly once. Holding the button high gives only one flip.
- R5: While paused, `led_o` keeps the value it showed when the pause took effect.
- R6: Resuming continues from the held value. With the button raised before clock edge 1, the first change appears at edge `DEBOUNCE_CYCLES + TICK_CYCLES + 3`, counting the first edge after the rise as edge 1.
- R7: A button level that lasts fewer than `DEBOUNCE_CYCLES` clocks does not change the run state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_raw | input | 1 | Unsynchronized, possibly bouncing push-button level, high when pressed |
| led_o | output | 8 | Registered LED pattern; bit 7 is the leftmost LED |

## Verification
Long, clean presses are timed to the exact edge. This separates a prescaler that restarts on each toggle from one that keeps its partial count. Runs of nine or more steps separate a correct wrap back to 8'h00 from a broken lookup or order. Short pulses during both run and pause separate a real debounce filter from a simple synchronizer. A held button separates edge detection from level sensing. Random mixes of presses, glitches and idle gaps from a fixed seed vary the phase of the presses against the step tick. A reset in the middle of a run checks the return to 8'h00 and to the paused state.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  localparam int STEP_W = 2;
  localparam int LED_W  = 8;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [LED_W-1:0]  led_t;

  // Step index to LED image; bit 7 is the leftmost LED.
  function automatic led_t step_to_led(input step_t s);
    led_t v;
    case (s)
      2'd0:    v = 8'h00;
      2'd1:    v = 8'h03;
      2'd2:    v = 8'h40;
      default: v = 8'hE8;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/led_seq_sync.sv
module led_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/led_seq_debounce.sv
module led_seq_debounce #(
  parameter int CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic press_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          stable_q;
  logic          stable_d_q;

  // The filtered level follows the input only after CYCLES differing edges in a row.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (level_i == stable_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q    <= '0;
      stable_q <= level_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stable_d_q <= 1'b0;
    else        stable_d_q <= stable_q;
  end

  assign press_o = stable_q & ~stable_d_q;
endmodule

// File: rtl/led_seq_prescaler.sv
module led_seq_prescaler #(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  // The count is held while paused and cleared on every toggle.
  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) cnt_q <= '0;
    else if (tick_o)       cnt_q <= '0;
    else if (run_i)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/led_seq_stepper.sv
module led_seq_stepper
  import led_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_i,
  input  logic tick_i,
  output logic run_o,
  output led_t led_o
);
  step_t step_q;
  step_t step_nx;

  always_comb begin
    step_nx = step_q;
    if (tick_i) step_nx = step_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o  <= 1'b0;
      step_q <= '0;
      led_o  <= '0;
    end else begin
      run_o  <= run_o ^ toggle_i;
      step_q <= step_nx;
      led_o  <= step_to_led(step_nx);
    end
  end
endmodule

// File: rtl/led_pattern_seq.sv
module led_pattern_seq #(
  parameter int TICK_CYCLES     = 50_000_000,
  parameter int DEBOUNCE_CYCLES = 500_000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_raw,
  output logic [7:0] led_o
);
  logic btn_sync_w;
  logic press_w;
  logic run_w;
  logic tick_w;

  led_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(btn_raw), .dout(btn_sync_w)
  );

  led_seq_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_db (
    .clk(clk), .rst_n(rst_n), .level_i(btn_sync_w), .press_o(press_w)
  );

  led_seq_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .clear_i(press_w), .tick_o(tick_w)
  );

  led_seq_stepper u_step (
    .clk(clk), .rst_n(rst_n), .toggle_i(press_w), .tick_i(tick_w),
    .run_o(run_w), .led_o(led_o)
  );
endmodule

// File: rtl/led_pattern_seq_chk.sv
module led_pattern_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] led_o,
  input logic       run,
  input logic       tick,
  input logic       press
);
  function automatic logic [7:0] follow(input logic [7:0] v);
    logic [7:0] r;
    if (v == 8'h00)      r = 8'h03;
    else if (v == 8'h03) r = 8'h40;
    else if (v == 8'h40) r = 8'hE8;
    else                 r = 8'h00;
    return r;
  endfunction

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> led_o == 8'h00);

  assert_cycle_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (led_o != $past(led_o)) |-> led_o == follow($past(led_o)));

  assert_tick_only_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  assert_press_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);

  assert_press_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> run != $past(run));

  assert_paused_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(led_o));
endmodule

bind led_pattern_seq led_pattern_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .led_o(led_o),
  .run(run_w), .tick(tick_w), .press(press_w)
);

// File: tb/led_pattern_seq_test.sv
module led_pattern_seq_test;
  localparam int TICK = 20;
  localparam int DB   = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       btn;
  logic [7:0] led;

  led_pattern_seq #(.TICK_CYCLES(TICK), .DEBOUNCE_CYCLES(DB), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn), .led_o(led)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] next_val(input logic [7:0] v);
    case (v)
      8'h00:   return 8'h03;
      8'h03:   return 8'h40;
      8'h40:   return 8'hE8;
      default: return 8'h00;
    endcase
  endfunction

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int wd_fails = 0;
  logic expect_paused = 1'b1;
  int   press_seq = 0;
  logic model_run = 1'b0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: led=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: order (R2), no motion while paused (R5), step period (R3).
  logic [7:0] prev_led = 8'h00;
  int cyc = 0, last_cyc = 0, seen_seq = 0;
  logic armed = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (seen_seq != press_seq) begin
      seen_seq = press_seq;
      armed = 1'b0;
    end
    if (rst_n !== 1'b1) begin
      prev_led = led;
      armed = 1'b0;
    end else if (led != prev_led) begin
      mon_checks++;
      if (led != next_val(prev_led)) begin
        mon_fails++;
        $display("FAIL R2: led=%h expected=%h", led, next_val(prev_led));
      end
      mon_checks++;
      if (expect_paused) begin
        mon_fails++;
        $display("FAIL R5: led=%h expected=%h (paused)", led, prev_led);
      end
      if (armed) begin
        mon_checks++;
        if (cyc - last_cyc != TICK) begin
          mon_fails++;
          $display("FAIL R3: period=%0d expected=%0d", cyc - last_cyc, TICK);
        end
      end
      armed = 1'b1;
      last_cyc = cyc;
      prev_led = led;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Long clean press that flips the run state (R4).
  task automatic long_press(input int hold);
    press_seq++;
    model_run = !model_run;
    if (model_run) expect_paused = 1'b0;
    btn = 1'b1;
    wait_n(DB + 4);
    if (!model_run) expect_paused = 1'b1;
    wait_n(hold);
    btn = 1'b0;
    wait_n(DB + 4);
  endtask

  task automatic glitch(input int len);
    btn = 1'b1;
    wait_n(len);
    btn = 1'b0;
    wait_n(DB + 3);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d",
             checks + mon_checks + wd_fails, fails + mon_fails + wd_fails);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    if (!finished) begin
      wd_fails = 1;
      $display("FAIL watchdog: led=%h expected=%h", led, led);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    btn   = 1'b0;
    wait_n(5);
    check(led == 8'h00, "R1 reset value", led, 8'h00);
    rst_n = 1'b1;
    wait_n(3 * TICK);
    check(led == 8'h00, "R1 paused after reset", led, 8'h00);

    // R6/R4: exact first-change edge after a press, then a held button.
    press_seq++; model_run = 1'b1; expect_paused = 1'b0;
    btn = 1'b1;
    wait_n(DB + TICK + 2);
    check(led == 8'h00, "R6 no change before full period", led, 8'h00);
    wait_n(1);
    check(led == 8'h03, "R6 first change timing", led, 8'h03);
    wait_n(3 * TICK);
    check(led != 8'h03, "R4 held button keeps running", led, 8'h03);
    btn = 1'b0;
    wait_n(10 * TICK);  // over two full cycles, R2/R3 by monitor

    // R5: pause and hold.
    long_press(2);
    held = led;
    wait_n(3 * TICK);
    check(led == held, "R5 paused holds", led, held);

    // R7: short pulses while paused.
    for (int i = 0; i < 4; i++) glitch(1 + int'($urandom % (DB - 1)));
    wait_n(2 * TICK);
    check(led == held, "R7 glitch while paused", led, held);

    // R6: resume from the same step.
    press_seq++; model_run = 1'b1; expect_paused = 1'b0;
    btn = 1'b1;
    wait_n(DB + TICK + 2);
    check(led == held, "R6 resume waits full period", led, held);
    wait_n(1);
    check(led == next_val(held), "R6 resume from held step", led, next_val(held));
    btn = 1'b0;
    wait_n(DB + 4);

    // R7: short pulses while running.
    for (int i = 0; i < 4; i++) glitch(1 + int'($urandom % (DB - 1)));
    held = led;
    wait_n(TICK + 1);
    check(led != held, "R7 still running after glitches", led, held);

    // Random mix.
    for (int i = 0; i < 20; i++) begin
      int r = int'($urandom % 3);
      if (r == 0)      glitch(1 + int'($urandom % (DB - 1)));
      else if (r == 1) long_press(int'($urandom % (2 * TICK)));
      else             wait_n(1 + int'($urandom % (2 * TICK)));
      if (!model_run) begin
        held = led;
        wait_n(TICK + 2);
        check(led == held, "R5 random paused holds", led, held);
      end
    end

    // R1: reset in mid-run.
    if (!model_run) long_press(2);
    wait_n(TICK + 3);
    rst_n = 1'b0;
    wait_n(1);
    check(led == 8'h00, "R1 mid-run reset", led, 8'h00);
    wait_n(2);
    expect_paused = 1'b1; model_run = 1'b0;
    rst_n = 1'b1;
    wait_n(3 * TICK);
    check(led == 8'h00, "R1 paused after mid-run reset", led, 8'h00);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule